// File: doc/BRIEF.md
# Dual-Role Processor Timer

This block is a timer for one processor. A single mode input selects its role. In counter role it counts clock ticks up to a programmable limit, wraps back to zero, and on each wrap sets a reached flag and raises an interrupt. In user role the same storage becomes a wide up-counter that software starts and stops. Software reads and loads that counter as two bus words, and it never raises the interrupt.

The bus is word-indexed, with four register slots. Address 0 is the limit slot, 1 the count slot, 2 the status slot and 3 the limit-keep slot, which changes the limit without restarting the count. Reads return data on `rdata_o` one clock after the read strobe. The data reflects the state before that clock edge.

Tick counts sit above `FRAC_W` zero bits in every word. The counter-role limit field is `WORD_W-1-FRAC_W` bits wide. The user count is `2*WORD_W-1-FRAC_W` bits wide and spans both words, with the reached flag in the top bit of the upper word. The block watches the mode input and reacts to each of its edges with a fixed sequence of actions.

Top module: `dual_role_timer`

## Requirements
- R1: After reset `rdata_o` and `irq_o` are 0 and the block is in counter role with limit 0, count 0 and the running flag set. A first count read returns 0, a status read returns 1 and a limit read returns 0.
- R2: Reads are registered. Each read returns the pre-edge state one clock after `rd_en_i`, and `rdata_o` holds its value until the next read. Slot codes: 0 limit, 1 count, 2 status, 3 limit-keep (reads 0).
- R3: In counter role with limit L not 0, the count advances once per clock through 0..L-1. The clock that wraps it from L-1 to 0 sets the reached flag and `irq_o`. With L = 0 the period is 2^(WORD_W-1-FRAC_W) clocks. A count read returns {reached, count, FRAC_W zeros}.
- R4: In counter role, a limit write loads wdata[WORD_W-2:FRAC_W], zeroes the count and clears the reached flag and `irq_o`. A limit read returns {0, limit, zeros} and clears the reached flag and `irq_o`, unless a wrap happens on the same clock.
- R5: A limit-keep write in counter role loads the limit and leaves the count running. If the count is already at or above the new limit minus one, it wraps on the next clock.
- R6: In counter role, writes to the count and status slots are ignored, and the running flag stays 1.
- R7: When `mode_i` rises, `irq_o` drops, the timer stops, the running flag clears and the limit is forced to all ones. The count value is kept.
- R8: In user role, a limit read returns {reached, upper count bits} and a count read returns {lower LOW_W count bits, FRAC_W zeros}, with LOW_W = WORD_W-FRAC_W. Reading does not clear the reached flag.
- R9: In user role, a limit write loads the upper count bits from wdata[WORD_W-2:0]. A count write loads the lower count bits from wdata[WORD_W-1:FRAC_W]. Both clear the reached flag and keep the limit at all ones.
- R10: In user role, status bit 0 starts (1) or stops (0) the counter, and a write that does not change the state has no effect. The clock of a start does not advance the count, and the clock of a stop still does. A stopped count holds.
- R11: A user count wrapping from all ones to zero sets the reached flag, and `irq_o` stays 0 throughout user role.
- R12: When `mode_i` falls, the running flag is set and the count is zeroed, while the limit keeps the all-ones value from user role. Limit-keep writes in user role are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register slot index |
| wdata_i | input | WORD_W | Write data |
| rdata_o | output | WORD_W | Registered read data |
| mode_i | input | 1 | Role select: 0 counter, 1 user timer |
| irq_o | output | 1 | Counter-role wrap interrupt |

## Verification
The bench builds the block with WORD_W = 8 and FRAC_W = 2. This leaves a 5-bit limit field and a 13-bit user count. Every nonzero limit is swept at two run lengths, on both sides of its wrap, and every one of the 8192 user count values is loaded and read back through both words. The user-count overflow, the free-running limit-0 period and the limit-keep shrink case all happen within a few dozen clocks.

// File: rtl/dual_role_timer_pkg.sv
package dual_role_timer_pkg;

   typedef enum logic [1:0] {
      SLOT_LIMIT = 2'd0,
      SLOT_COUNT = 2'd1,
      SLOT_STATUS = 2'd2,
      SLOT_LIMIT_KEEP = 2'd3
   } slot_e;

   localparam int NUM_SLOTS = 4;

   typedef struct packed {
      logic lim;
      logic cnt;
      logic sts;
      logic keep;
   } strobe_t;

endpackage

// File: rtl/dual_role_timer_dec.sv
module dual_role_timer_dec
   import dual_role_timer_pkg::*;
(
   input  logic       wr_en_i,
   input  logic       rd_en_i,
   input  logic [1:0] addr_i,
   output strobe_t    wr_s_o,
   output strobe_t    rd_s_o
);
   logic [NUM_SLOTS-1:0] wr_vec;
   logic [NUM_SLOTS-1:0] rd_vec;

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      assign wr_vec[i] = wr_en_i && (addr_i == 2'(i));
      assign rd_vec[i] = rd_en_i && (addr_i == 2'(i));
   end

   assign wr_s_o = '{lim: wr_vec[SLOT_LIMIT], cnt: wr_vec[SLOT_COUNT],
                     sts: wr_vec[SLOT_STATUS], keep: wr_vec[SLOT_LIMIT_KEEP]};
   assign rd_s_o = '{lim: rd_vec[SLOT_LIMIT], cnt: rd_vec[SLOT_COUNT],
                     sts: rd_vec[SLOT_STATUS], keep: rd_vec[SLOT_LIMIT_KEEP]};
endmodule

// File: rtl/dual_role_timer_mode.sv
module dual_role_timer_mode (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mode_i,
   output logic mode_q_o,
   output logic to_user_o,
   output logic to_cnt_o
);
   logic mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= 1'b0;
      else         mode_q <= mode_i;
   end

   assign mode_q_o  = mode_q;
   assign to_user_o = mode_i && !mode_q;
   assign to_cnt_o  = !mode_i && mode_q;
endmodule

// File: rtl/dual_role_timer_core.sv
module dual_role_timer_core
   import dual_role_timer_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int FRAC_W = 9,
   localparam int LIM_W = WORD_W - 1 - FRAC_W,
   localparam int UCNT_W = 2 * WORD_W - 1 - FRAC_W,
   localparam int LOW_W = WORD_W - FRAC_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              user_q_i,
   input  logic              to_user_i,
   input  logic              to_cnt_i,
   input  strobe_t           wr_s_i,
   input  logic              rd_lim_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [UCNT_W-1:0] cnt_o,
   output logic [LIM_W-1:0]  lim_o,
   output logic              reached_o,
   output logic              run_o,
   output logic              irq_o
);
   logic [UCNT_W-1:0] cnt_q;
   logic [LIM_W-1:0]  lim_q;
   logic              reached_q, run_q, irq_q;

   logic [LIM_W-1:0] cnt_lo;
   logic [LIM_W-1:0] lim_m1;
   logic             lim_zero, cnt_term, usr_term;

   always_comb begin
      cnt_lo   = cnt_q[LIM_W-1:0];
      lim_zero = (lim_q == '0);
      lim_m1   = lim_q - LIM_W'(1);
      cnt_term = lim_zero ? (&cnt_lo) : (cnt_lo >= lim_m1);
      usr_term = &cnt_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         lim_q     <= '0;
         reached_q <= 1'b0;
         run_q     <= 1'b1;
         irq_q     <= 1'b0;
      end else if (to_user_i) begin
         irq_q <= 1'b0;
         run_q <= 1'b0;
         lim_q <= '1;
      end else if (to_cnt_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
      end else if (user_q_i) begin
         if (wr_s_i.lim) begin
            cnt_q[UCNT_W-1:LOW_W] <= wdata_i[WORD_W-2:0];
            reached_q <= 1'b0;
            lim_q     <= '1;
         end else if (wr_s_i.cnt) begin
            cnt_q[LOW_W-1:0] <= wdata_i[WORD_W-1:FRAC_W];
            reached_q <= 1'b0;
            lim_q     <= '1;
         end else if (run_q) begin
            cnt_q <= cnt_q + UCNT_W'(1);
            if (usr_term) reached_q <= 1'b1;
         end
         if (wr_s_i.sts) run_q <= wdata_i[0];
      end else begin
         if (wr_s_i.lim) begin
            lim_q     <= wdata_i[WORD_W-2:FRAC_W];
            cnt_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
         end else begin
            if (wr_s_i.keep) lim_q <= wdata_i[WORD_W-2:FRAC_W];
            if (rd_lim_i) begin
               reached_q <= 1'b0;
               irq_q     <= 1'b0;
            end
            if (run_q) begin
               if (cnt_term) begin
                  cnt_q     <= '0;
                  reached_q <= 1'b1;
                  irq_q     <= 1'b1;
               end else begin
                  cnt_q <= cnt_q + UCNT_W'(1);
               end
            end
         end
      end
   end

   assign cnt_o     = cnt_q;
   assign lim_o     = lim_q;
   assign reached_o = reached_q;
   assign run_o     = run_q;
   assign irq_o     = irq_q;
endmodule

// File: rtl/dual_role_timer_rdata.sv
module dual_role_timer_rdata
   import dual_role_timer_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int FRAC_W = 9,
   parameter bit READ_REG = 1'b1,
   localparam int LIM_W = WORD_W - 1 - FRAC_W,
   localparam int UCNT_W = 2 * WORD_W - 1 - FRAC_W,
   localparam int LOW_W = WORD_W - FRAC_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  strobe_t           rd_s_i,
   input  logic              user_q_i,
   input  logic [UCNT_W-1:0] cnt_i,
   input  logic [LIM_W-1:0]  lim_i,
   input  logic              reached_i,
   input  logic              run_i,
   output logic [WORD_W-1:0] rdata_o
);
   logic [WORD_W-1:0] value;
   logic              rd_any;

   assign rd_any = |rd_s_i;

   always_comb begin
      value = '0;
      if (rd_s_i.lim) begin
         value = user_q_i ? {reached_i, cnt_i[UCNT_W-1:LOW_W]}
                          : {1'b0, lim_i, {FRAC_W{1'b0}}};
      end else if (rd_s_i.cnt) begin
         value = user_q_i ? {cnt_i[LOW_W-1:0], {FRAC_W{1'b0}}}
                          : {reached_i, cnt_i[LIM_W-1:0], {FRAC_W{1'b0}}};
      end else if (rd_s_i.sts) begin
         value = {{(WORD_W-1){1'b0}}, run_i};
      end
   end

   if (READ_REG) begin : g_reg
      logic [WORD_W-1:0] rdata_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     rdata_q <= '0;
         else if (rd_any) rdata_q <= value;
      end
      assign rdata_o = rdata_q;
   end else begin : g_comb
      assign rdata_o = rd_any ? value : '0;
   end
endmodule

// File: rtl/dual_role_timer.sv
module dual_role_timer
   import dual_role_timer_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int FRAC_W = 9,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [1:0]        addr_i,
   input  logic [WORD_W-1:0] wdata_i,
   output logic [WORD_W-1:0] rdata_o,
   input  logic              mode_i,
   output logic              irq_o
);
   localparam int LIM_W  = WORD_W - 1 - FRAC_W;
   localparam int UCNT_W = 2 * WORD_W - 1 - FRAC_W;

   initial begin
      assert (WORD_W >= 4) else $error("WORD_W must be at least 4");
      assert (FRAC_W >= 1) else $error("FRAC_W must be at least 1");
      assert (FRAC_W <= WORD_W - 2) else $error("FRAC_W leaves no limit field");
   end

   strobe_t           wr_s, rd_s;
   logic              mode_q, to_user, to_cnt;
   logic [UCNT_W-1:0] cnt_q;
   logic [LIM_W-1:0]  lim_q;
   logic              reached_q, run_q;

   dual_role_timer_dec u_dec (
      .wr_en_i (wr_en_i),
      .rd_en_i (rd_en_i),
      .addr_i  (addr_i),
      .wr_s_o  (wr_s),
      .rd_s_o  (rd_s)
   );

   dual_role_timer_mode u_mode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode_i),
      .mode_q_o  (mode_q),
      .to_user_o (to_user),
      .to_cnt_o  (to_cnt)
   );

   dual_role_timer_core #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .user_q_i  (mode_q),
      .to_user_i (to_user),
      .to_cnt_i  (to_cnt),
      .wr_s_i    (wr_s),
      .rd_lim_i  (rd_s.lim),
      .wdata_i   (wdata_i),
      .cnt_o     (cnt_q),
      .lim_o     (lim_q),
      .reached_o (reached_q),
      .run_o     (run_q),
      .irq_o     (irq_o)
   );

   dual_role_timer_rdata #(.WORD_W(WORD_W), .FRAC_W(FRAC_W), .READ_REG(READ_REG)) u_rdata (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_s_i    (rd_s),
      .user_q_i  (mode_q),
      .cnt_i     (cnt_q),
      .lim_i     (lim_q),
      .reached_i (reached_q),
      .run_i     (run_q),
      .rdata_o   (rdata_o)
   );
endmodule

// File: rtl/dual_role_timer_chk.sv
module dual_role_timer_chk #(
   parameter int WORD_W = 32,
   parameter int FRAC_W = 9,
   localparam int LIM_W = WORD_W - 1 - FRAC_W,
   localparam int UCNT_W = 2 * WORD_W - 1 - FRAC_W
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic              rd_en_i,
   input logic [1:0]        addr_i,
   input logic              mode_i,
   input logic              irq_o,
   input logic              mode_q,
   input logic [UCNT_W-1:0] cnt_q,
   input logic [LIM_W-1:0]  lim_q,
   input logic              reached_q,
   input logic              run_q
);
   AST_IRQ_WITH_REACHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> reached_q); // R3

   AST_CNT_ROLE_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mode_q |-> run_q); // R6

   AST_ENTER_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i && !mode_q) |=> (!run_q && !irq_o && (&lim_q))); // R7

   AST_USER_READ_KEEPS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q && mode_i && rd_en_i && !wr_en_i && addr_i == 2'd0 && reached_q)
      |=> reached_q); // R8

   AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q && mode_i && !run_q && !wr_en_i) |=> $stable(cnt_q)); // R10

   AST_USER_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q |-> !irq_o); // R11

   AST_LEAVE_USER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mode_i && mode_q) |=> (run_q && cnt_q == '0 && !mode_q)); // R12
endmodule

bind dual_role_timer dual_role_timer_chk #(.WORD_W(WORD_W), .FRAC_W(FRAC_W)) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .wr_en_i   (wr_en_i),
   .rd_en_i   (rd_en_i),
   .addr_i    (addr_i),
   .mode_i    (mode_i),
   .irq_o     (irq_o),
   .mode_q    (mode_q),
   .cnt_q     (cnt_q),
   .lim_q     (lim_q),
   .reached_q (reached_q),
   .run_q     (run_q)
);

// File: tb/dual_role_timer_bench.sv
`timescale 1ns/1ps
module dual_role_timer_bench;
   localparam int W = 8;
   localparam int F = 2;

   logic         clk = 1'b0;
   logic         rst_ni = 1'b0;
   logic         wr_en = 1'b0, rd_en = 1'b0, mode = 1'b0;
   logic [1:0]   addr = 2'd0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         irq;

   int nvec = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dual_role_timer #(.WORD_W(W), .FRAC_W(F)) u_dual_role_timer (
      .clk_i   (clk),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en),
      .rd_en_i (rd_en),
      .addr_i  (addr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .mode_i  (mode),
      .irq_o   (irq)
   );

   task automatic check(input string req, input int act, input int exp);
      nvec++;
      if (act != exp) begin
         nbad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus(input bit wr, input bit rd, input logic [1:0] a, input int d);
      wr_en = wr; rd_en = rd; addr = a; wdata = W'(d);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input int d);
      bus(1'b1, 1'b0, a, d);
   endtask

   task automatic rd(input logic [1:0] a);
      bus(1'b0, 1'b1, a, 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   endtask

   initial begin
      #(4 * 190000);
      nbad++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      // R1 reset state
      check("R1 rdata after reset", rdata, 0);
      check("R1 irq after reset", irq, 0);
      rd(1); check("R1 first count read", rdata, 0);
      rd(2); check("R1 running flag", rdata, 1);
      rd(0); check("R1 limit zero", rdata, 0);
      check("R2 rdata held", rdata, 0);

      // R3 / R4 sweep of every nonzero limit
      for (int L = 1; L < 32; L++) begin
         for (int k = 0; k < 2; k++) begin
            int n;
            n = (k == 0) ? L - 1 : 2 * L + 1;
            wr(0, L << 2);
            idle(n);
            rd(1);
            check("R3 count read", rdata, ((n >= L) ? 128 : 0) + ((n % L) << 2));
            check("R3 irq on wrap", irq, (n + 1 >= L) ? 1 : 0);
            rd(0);
            check("R4 limit read", rdata, L << 2);
            check("R4 irq cleared by limit read", irq, ((n + 2) % L == 0) ? 1 : 0);
         end
      end

      // R3 free-running limit 0
      wr(0, 0); idle(40); rd(1);
      check("R3 free run period", rdata, 128 + ((40 % 32) << 2));

      // R6 counter role ignores count and status writes
      wr(0, 10 << 2); idle(2); wr(1, 8'hFF); idle(1); rd(1);
      check("R6 count write ignored", rdata, 4 << 2);
      wr(2, 0); rd(2);
      check("R6 status stays running", rdata, 1);

      // R5 limit-keep grow and shrink
      wr(0, 10 << 2); idle(3); wr(3, 20 << 2); idle(10); rd(1);
      check("R5 keep grow continues", rdata, 14 << 2);
      wr(0, 20 << 2); idle(9); wr(3, 5 << 2); idle(1); rd(1);
      check("R5 keep shrink wraps", rdata, 128);
      rd(0); check("R4 limit after keep", rdata, 5 << 2);
      rd(1); check("R4 reached cleared", rdata, 2 << 2);
      check("R4 irq cleared", irq, 0);

      // R7 enter user role with irq pending
      wr(0, 3 << 2); idle(5);
      check("R3 irq pending", irq, 1);
      mode = 1'b1; idle(1);
      check("R7 irq dropped", irq, 0);
      rd(2); check("R7 running cleared", rdata, 0);
      rd(1); check("R7 count kept", rdata, 2 << 2);
      idle(3);
      rd(1); check("R10 stopped count holds", rdata, 2 << 2);
      rd(0); check("R8 upper with reached", rdata, 128);
      rd(0); check("R8 reached not cleared", rdata, 128);
      check("R11 no irq in user role", irq, 0);

      // R9 exhaustive load and readback of both words
      for (int v = 0; v < 8192; v++) begin
         wr(0, 128 | (v >> 6));
         wr(1, ((v & 63) << 2) | 3);
         rd(1); check("R9 lower word load", rdata, (v & 63) << 2);
         rd(0); check("R9 upper word load", rdata, v >> 6);
      end

      // R10 start, redundant start, stop, redundant stop
      wr(0, 100 >> 6); wr(1, (100 & 63) << 2);
      wr(2, 1); idle(7);
      rd(1); check("R10 count after start", rdata, (107 & 63) << 2);
      rd(0); check("R10 upper while running", rdata, 108 >> 6);
      wr(2, 1); idle(2);
      rd(1); check("R10 redundant start", rdata, (112 & 63) << 2);
      wr(2, 0); idle(5);
      rd(1); check("R10 stop edge counts", rdata, (114 & 63) << 2);
      wr(2, 0);
      rd(1); check("R10 redundant stop", rdata, (114 & 63) << 2);

      // R11 overflow
      wr(0, 8190 >> 6); wr(1, (8190 & 63) << 2);
      wr(2, 1); idle(3);
      rd(1); check("R11 wrapped count", rdata, 1 << 2);
      rd(0); check("R11 reached set", rdata, 128);
      check("R11 irq stays low", irq, 0);
      rd(0); check("R8 reached held", rdata, 128);
      wr(1, 0);
      rd(0); check("R9 write clears reached", rdata, 0);
      wr(2, 0);

      // R12 keep write ignored, then return to counter role
      wr(3, 5 << 2);
      mode = 1'b0; idle(1);
      rd(0); check("R12 limit stays max", rdata, 31 << 2);
      rd(2); check("R12 running set", rdata, 1);
      rd(1); check("R12 count restarted", rdata, 2 << 2);

      finish_run();
   end
endmodule